// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a bank of general-purpose pins behind a small register bus with cycle, strobe, write-enable, address, data and byte-select signals and a one-cycle acknowledge. Each pin can act as an output or as an input. When it is an output it drives a value that software has written. When it is an input it is sampled through a two-stage synchronizer, and software can read its level.

Input pins can raise interrupts. Each pin has a mask bit, a rising-edge enable bit and a falling-edge enable bit. An enabled edge on an unmasked pin sets a sticky status bit. Software clears a status bit by writing a one to a separate clear register.

Status feeds a second-level global interrupt register of `GW` bits. While any pin status bit is set, the bit at position `GBIT` of that register is held set. The other bits of the register are set by spare interrupt-source inputs. Each global bit is cleared by writing it with a one. A global mask gates these bits onto one interrupt output line.

The bus interface is a two-state machine. In state IDLE, a request (cycle and strobe both high) performs the write or captures the read data and moves to RESP. RESP drives the acknowledge for exactly one cycle and always returns to IDLE.

Top module: `gpio_edge_ctrl`

Word map (word index = address bits [5:2]): 0 direction, 1 output data, 2 input level (read-only), 3 interrupt mask, 4 rising enable, 5 falling enable, 6 status clear (write-one, reads 0), 7 status (read-only), 8 global interrupt (write-one-to-clear), 9 global mask.

## Requirements
- R1: After reset, direction, output data, mask, both edge enables, status, global register and global mask all read 0. The output enables are all 0, and the interrupt line and the acknowledge are low.
- R2: A direction bit of 1 raises that pin's output enable, and the pin output carries the matching output-data bit. A direction bit of 0 drops the output enable.
- R3: Reading word 2 returns the synchronized level of every pin; the level is readable from the third clock edge after the pin changes.
- R4: A status bit sets only when its mask bit is 1 and an edge of an enabled polarity occurs. A pulse on a masked-off pin leaves its status bit 0.
- R5: A status bit stays set after the pin returns to its earlier level. Writing 1 to its position in word 6 clears it, and writing 0 leaves it unchanged.
- R6: With rising edges only, a pulse from all-zeros leaves status equal to the driven value. With falling edges only, a pulse from all-ones leaves status equal to the bitwise complement of the driven value.
- R7: Global bit 15 is set while any status bit is set. Spare source input k sets global bit k. The interrupt line is the OR of the global bits ANDed with the global mask, so clearing mask bit 15 keeps the line low.
- R8: Writing 1 to global bit 15 clears it, but it sets again while pin status remains. After status and then the global bit are cleared, both read 0 and the interrupt line is low.
- R9: Every access gets an acknowledge that is high for exactly one cycle. Reading word 6 returns 0.
- R10: Byte select bit n qualifies writes to data bits [8n+7:8n]; lanes whose select bit is 0 keep their old value.
- R11: An enabled edge raises the interrupt line (with mask bits set) within 20 clock cycles of the pin change.
- R12: When an edge and a clear of the same status bit fall in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cyc_i | input | 1 | Bus cycle active |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | ADDR_W (6) | Byte address |
| bus_dat_i | input | DW (32) | Write data |
| bus_sel_i | input | DW/8 (4) | Byte lane selects |
| bus_dat_o | output | DW (32) | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| pin_i | input | NPINS (32) | Pin input levels |
| pin_o | output | NPINS (32) | Pin output values |
| pin_oe_o | output | NPINS (32) | Pin output enables |
| girq_src_i | input | GW (16) | Spare global interrupt sources |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
The bench builds the block with its defaults: 32 pins, a 32-bit bus with four byte lanes, and a 16-bit global register whose pin-status bit sits at position 15. With these values every pin bit, every byte lane and the fixed global position can be reached with full-width patterns such as 0x55555555, 0xA5A5A5A5 and their complements. A spare source at a low bit position can then be checked against bit 15. The bench also times a pin change so that the status set coincides with a clear write, which exercises the set-over-clear rule.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_t;

    localparam int unsigned REG_IDX_W = 4;

    localparam logic [REG_IDX_W-1:0] W_DIR   = 4'd0;
    localparam logic [REG_IDX_W-1:0] W_ODATA = 4'd1;
    localparam logic [REG_IDX_W-1:0] W_LEVEL = 4'd2;
    localparam logic [REG_IDX_W-1:0] W_MASK  = 4'd3;
    localparam logic [REG_IDX_W-1:0] W_RISE  = 4'd4;
    localparam logic [REG_IDX_W-1:0] W_FALL  = 4'd5;
    localparam logic [REG_IDX_W-1:0] W_CLR   = 4'd6;
    localparam logic [REG_IDX_W-1:0] W_STAT  = 4'd7;
    localparam logic [REG_IDX_W-1:0] W_GINT  = 4'd8;
    localparam logic [REG_IDX_W-1:0] W_GMASK = 4'd9;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_edge_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cyc_i,
    input  logic stb_i,
    input  logic we_i,
    output logic ack_o,
    output logic wr_fire_o,
    output logic rd_fire_o
);

    bus_state_t state_q, state_d;
    logic       req;

    assign req = cyc_i && stb_i;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= BUS_IDLE;
        else         state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        ack_o     = 1'b0;
        wr_fire_o = 1'b0;
        rd_fire_o = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (req) begin
                    wr_fire_o = we_i;
                    rd_fire_o = !we_i;
                    state_d   = BUS_RESP;
                end
            end
            BUS_RESP: begin
                ack_o   = 1'b1;
                state_d = BUS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o
);

    logic [NPINS-1:0] meta_q, sync_q, prev_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pin_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
        assign fall_o[i] = ~sync_q[i] & prev_q[i];
    end

    assign level_o = sync_q;

endmodule

// File: rtl/gpio_sticky_bits.sv
module gpio_sticky_bits #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // a set in the same cycle as a clear wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= (q_o & ~clr_i) | set_i;
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned GW     = 16,
    parameter int unsigned GBIT   = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_cyc_i,
    input  logic              bus_stb_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_adr_i,
    input  logic [DW-1:0]     bus_dat_i,
    input  logic [DW/8-1:0]   bus_sel_i,
    output logic [DW-1:0]     bus_dat_o,
    output logic              bus_ack_o,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o,
    input  logic [GW-1:0]     girq_src_i,
    output logic              irq_o
);

    localparam int unsigned LANES = DW / 8;

    logic                 wr_fire, rd_fire;
    logic [REG_IDX_W-1:0] widx;
    logic [DW-1:0]        lane_mask, wval;
    logic [NPINS-1:0]     pmask;
    logic [GW-1:0]        gmask_w;

    logic [NPINS-1:0] dir_q, odata_q, imask_q, rise_en_q, fall_en_q;
    logic [GW-1:0]    gmask_q;
    logic [NPINS-1:0] level, rise, fall;
    logic [NPINS-1:0] istat_q, istat_set, istat_clr;
    logic [GW-1:0]    gint_q, gint_set, gint_clr;
    logic             istat_clr_hit;
    logic [DW-1:0]    rd_mux;

    assign widx = bus_adr_i[REG_IDX_W+1:2];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*8 +: 8] = {8{bus_sel_i[l]}};
    end

    assign wval    = bus_dat_i & lane_mask;
    assign pmask   = lane_mask[NPINS-1:0];
    assign gmask_w = lane_mask[GW-1:0];

    gpio_bus_fsm u_bus (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cyc_i     (bus_cyc_i),
        .stb_i     (bus_stb_i),
        .we_i      (bus_we_i),
        .ack_o     (bus_ack_o),
        .wr_fire_o (wr_fire),
        .rd_fire_o (rd_fire)
    );

    gpio_pin_sampler #(.NPINS(NPINS)) u_smp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    function automatic logic [NPINS-1:0] merge_p(input logic [NPINS-1:0] old_v,
                                                  input logic [NPINS-1:0] new_v,
                                                  input logic [NPINS-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    // configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q     <= '0;
            odata_q   <= '0;
            imask_q   <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            gmask_q   <= '0;
        end else if (wr_fire) begin
            case (widx)
                W_DIR:   dir_q     <= merge_p(dir_q,     wval[NPINS-1:0], pmask);
                W_ODATA: odata_q   <= merge_p(odata_q,   wval[NPINS-1:0], pmask);
                W_MASK:  imask_q   <= merge_p(imask_q,   wval[NPINS-1:0], pmask);
                W_RISE:  rise_en_q <= merge_p(rise_en_q, wval[NPINS-1:0], pmask);
                W_FALL:  fall_en_q <= merge_p(fall_en_q, wval[NPINS-1:0], pmask);
                W_GMASK: gmask_q   <= (gmask_q & ~gmask_w) | wval[GW-1:0];
                default: ;
            endcase
        end
    end

    // pin status
    assign istat_clr_hit = wr_fire && (widx == W_CLR);
    assign istat_set     = imask_q & ((rise & rise_en_q) | (fall & fall_en_q));
    assign istat_clr     = istat_clr_hit ? wval[NPINS-1:0] : '0;

    gpio_sticky_bits #(.W(NPINS)) u_istat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (istat_set),
        .clr_i  (istat_clr),
        .q_o    (istat_q)
    );

    // global register
    always_comb begin
        gint_set       = girq_src_i;
        gint_set[GBIT] = girq_src_i[GBIT] | (|istat_q);
    end
    assign gint_clr = (wr_fire && (widx == W_GINT)) ? wval[GW-1:0] : '0;

    gpio_sticky_bits #(.W(GW)) u_gint (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (gint_set),
        .clr_i  (gint_clr),
        .q_o    (gint_q)
    );

    // read path
    always_comb begin
        rd_mux = '0;
        case (widx)
            W_DIR:   rd_mux[NPINS-1:0] = dir_q;
            W_ODATA: rd_mux[NPINS-1:0] = odata_q;
            W_LEVEL: rd_mux[NPINS-1:0] = level;
            W_MASK:  rd_mux[NPINS-1:0] = imask_q;
            W_RISE:  rd_mux[NPINS-1:0] = rise_en_q;
            W_FALL:  rd_mux[NPINS-1:0] = fall_en_q;
            W_STAT:  rd_mux[NPINS-1:0] = istat_q;
            W_GINT:  rd_mux[GW-1:0]    = gint_q;
            W_GMASK: rd_mux[GW-1:0]    = gmask_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      bus_dat_o <= '0;
        else if (rd_fire) bus_dat_o <= rd_mux;
    end

    assign pin_o    = odata_q;
    assign pin_oe_o = dir_q;
    assign irq_o    = |(gint_q & gmask_q);

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int unsigned NPINS = 32,
    parameter int unsigned GW    = 16,
    parameter int unsigned GBIT  = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc,
    input logic             stb,
    input logic             ack,
    input logic [NPINS-1:0] istat,
    input logic [NPINS-1:0] imask,
    input logic             clr_hit,
    input logic [GW-1:0]    gint
);

    // R9: acknowledge lasts one cycle
    a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R9: acknowledge only answers a request
    a_r9_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(cyc && stb));

    // R5: a status bit falls only after a clear write
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(istat) & ~istat)) |-> $past(clr_hit));

    // R4: a masked-off pin never gains status
    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(istat & ~$past(istat) & ~$past(imask))));

    // R7: any pin status drives the fixed global bit
    a_r7_gbit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|istat) |=> gint[GBIT]);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS), .GW(GW), .GBIT(GBIT)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .cyc     (bus_cyc_i),
    .stb     (bus_stb_i),
    .ack     (bus_ack_o),
    .istat   (istat_q),
    .imask   (imask_q),
    .clr_hit (istat_clr_hit),
    .gint    (gint_q)
);

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;

    localparam int NP = 32;
    localparam logic [5:0] A_DIR = 6'h00, A_ODATA = 6'h04, A_LEVEL = 6'h08,
                           A_MASK = 6'h0C, A_RISE = 6'h10, A_FALL = 6'h14,
                           A_CLR = 6'h18, A_STAT = 6'h1C, A_GINT = 6'h20,
                           A_GMASK = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [5:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic [3:0]  sel = '0;
    logic [31:0] rdat;
    logic        ack;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] pout, poe;
    logic [15:0] gsrc = '0;
    logic        irq;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_edge_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we), .bus_adr_i(adr),
        .bus_dat_i(wdat), .bus_sel_i(sel), .bus_dat_o(rdat), .bus_ack_o(ack),
        .pin_i(pins), .pin_o(pout), .pin_oe_o(poe),
        .girq_src_i(gsrc), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge with the bus idle; returns at a negedge with the bus idle
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        cyc = 1; stb = 1; we = 1; adr = a; wdat = d; sel = s;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ack) break;
        end
        cyc = 0; stb = 0; we = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        cyc = 1; stb = 1; we = 0; adr = a; sel = 4'hF;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ack) break;
        end
        d = rdat;
        cyc = 0; stb = 0;
        @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 oe", poe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 ack", {31'h0, ack}, 32'h0);
        read_check("R1 dir", A_DIR, 32'h0);
        read_check("R1 odata", A_ODATA, 32'h0);
        read_check("R1 mask", A_MASK, 32'h0);
        read_check("R1 rise", A_RISE, 32'h0);
        read_check("R1 fall", A_FALL, 32'h0);
        read_check("R1 stat", A_STAT, 32'h0);
        read_check("R1 gint", A_GINT, 32'h0);
        read_check("R1 gmask", A_GMASK, 32'h0);
    endtask

    task automatic t_output;
        bus_write(A_DIR, 32'hFFFF_FFFF);
        foreach (pat_list[k]) begin
            bus_write(A_ODATA, pat_list[k]);
            check("R2 pin_o", pout, pat_list[k]);
            check("R2 oe", poe, 32'hFFFF_FFFF);
        end
        bus_write(A_DIR, 32'h0000_FFFF);
        check("R2 oe partial", poe, 32'h0000_FFFF);
    endtask

    logic [31:0] pat_list [4] = '{32'h5555_5555, 32'hAAAA_AAAA, 32'h5A5A_5A5A, 32'hA5A5_A5A5};

    task automatic t_lanes;
        bus_write(A_DIR, 32'hFFFF_FFFF);
        bus_write(A_DIR, 32'h0000_0000, 4'b0010);
        read_check("R10 lane1 only", A_DIR, 32'hFFFF_00FF);
        bus_write(A_DIR, 32'h1234_5678, 4'b1001);
        read_check("R10 lanes 0,3", A_DIR, 32'h12FF_0078);
        bus_write(A_DIR, 32'h0);
    endtask

    task automatic t_input;
        foreach (pat_list[k]) begin
            pins = pat_list[k];
            settle(3);
            read_check("R3 level", A_LEVEL, pat_list[k]);
        end
        read_check("R9 clear reads 0", A_CLR, 32'h0);
    endtask

    task automatic t_ack;
        cyc = 1; stb = 1; we = 0; adr = A_DIR; sel = 4'hF;
        @(negedge clk);
        check("R9 ack high", {31'h0, ack}, 32'h1);
        cyc = 0; stb = 0;
        @(negedge clk);
        check("R9 ack one cycle", {31'h0, ack}, 32'h0);
    endtask

    task automatic clear_all;
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_write(A_GINT, 32'h0000_FFFF);
    endtask

    task automatic t_rise;
        bus_write(A_MASK, 32'hFFFF_FFFF);
        bus_write(A_RISE, 32'hFFFF_FFFF);
        bus_write(A_FALL, 32'h0);
        bus_write(A_GMASK, 32'h0000_FFFF);
        foreach (pat_list[k]) begin
            pins = '0; settle(4);
            clear_all();
            read_check("R8 stat clear", A_STAT, 32'h0);
            pins = pat_list[k]; settle(4);
            pins = '0; settle(4);
            read_check("R6 rise stat", A_STAT, pat_list[k]);
            read_check("R7 gint", A_GINT, 32'h0000_8000);
            check("R7 irq", {31'h0, irq}, 32'h1);
        end
        bus_write(A_CLR, 32'h0);
        read_check("R5 zero write keeps", A_STAT, pat_list[3]);
        bus_write(A_GINT, 32'h0000_8000);
        read_check("R8 gbit resets while stat", A_GINT, 32'h0000_8000);
        bus_write(A_CLR, 32'h0000_00FF);
        read_check("R5 partial clear", A_STAT, pat_list[3] & 32'hFFFF_FF00);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_write(A_GINT, 32'h0000_8000);
        read_check("R8 gint zero", A_GINT, 32'h0);
        read_check("R8 stat zero", A_STAT, 32'h0);
        check("R8 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_fall;
        bus_write(A_RISE, 32'h0);
        bus_write(A_FALL, 32'hFFFF_FFFF);
        foreach (pat_list[k]) begin
            pins = '1; settle(4);
            clear_all();
            pins = pat_list[k]; settle(4);
            pins = '1; settle(4);
            read_check("R6 fall stat", A_STAT, ~pat_list[k]);
        end
        clear_all();
    endtask

    task automatic t_mask;
        bus_write(A_RISE, 32'hFFFF_FFFF);
        bus_write(A_FALL, 32'h0);
        bus_write(A_MASK, 32'h0000_FFFF);
        pins = '0; settle(4);
        clear_all();
        pins = '1; settle(4);
        pins = '0; settle(4);
        read_check("R4 masked pins", A_STAT, 32'h0000_FFFF);
        bus_write(A_MASK, 32'hFFFF_FFFF);
        bus_write(A_RISE, 32'h0);
        clear_all();
        pins = '1; settle(4);
        pins = '0; settle(4);
        read_check("R4 no enabled polarity", A_STAT, 32'h0);
    endtask

    task automatic t_global;
        int cnt;
        bus_write(A_RISE, 32'hFFFF_FFFF);
        clear_all();
        bus_write(A_GMASK, 32'h0000_7FFF);
        pins = 32'h0000_0002; settle(6);
        read_check("R7 gbit set", A_GINT, 32'h0000_8000);
        check("R7 irq masked", {31'h0, irq}, 32'h0);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_write(A_GINT, 32'h0000_8000);
        gsrc = 16'h0008; @(negedge clk); gsrc = '0; settle(1);
        read_check("R7 spare bit", A_GINT, 32'h0000_0008);
        check("R7 spare irq", {31'h0, irq}, 32'h1);
        bus_write(A_GINT, 32'h0000_0008);
        bus_write(A_GMASK, 32'h0000_FFFF);
        pins = '0; settle(4);
        clear_all();
        check("R11 irq idle", {31'h0, irq}, 32'h0);
        pins = 32'h8000_0000;
        cnt = 0;
        while (!irq && cnt < 25) begin
            @(negedge clk);
            cnt++;
        end
        check("R11 latency within 20", {31'h0, (cnt <= 20)}, 32'h1);
        pins = '0; settle(4);
        clear_all();
    endtask

    task automatic t_collide;
        pins = '0; settle(4);
        clear_all();
        pins = 32'h0000_0001;
        settle(2);
        bus_write(A_CLR, 32'h0000_0001);
        read_check("R12 set wins", A_STAT, 32'h0000_0001);
        clear_all();
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_output();
        t_lanes();
        t_input();
        t_ack();
        t_rise();
        t_fall();
        t_mask();
        t_global();
        t_collide();
        finish_run();
    end

endmodule